// File: doc/BRIEF.md
# Packed Halving-Average Vector Unit

This block is a small vector execution unit with a private file of eight 64-bit vector registers. Its only arithmetic operation treats each register as four unsigned 16-bit lanes. For each lane it forms the mean of two elements, rounding down. A caller issues an operation by raising a valid strobe along with two source register numbers and one destination number. Both operands come from the vector file. The per-lane results are captured in a result register and written to the destination one cycle later, with a one-cycle done pulse marking that writeback.

Vectors reach the file through a separate load port, which writes a full 64-bit word into any register. A read port returns any register for storing. Reads of the file, for the operation's operands and for the read port alike, pass through a write-through bypass, so a register being written in the current cycle is seen with its new contents. When a load and a writeback target the same register in the same cycle, the writeback is kept.

Top module: `vavg_unit`

## Requirements
- R1: After reset all eight vector registers read as zero and `done` is low.
- R2: When `ldEn` is high, the 64-bit `ldData` is written into register `ldIdx` at the clock edge. It reads back unchanged on later cycles.
- R3: Lane k occupies bits [16k+15:16k] of a vector, k = 0..3. Each result lane equals bits 16:1 of the 17-bit unsigned sum of the matching source lanes, and is placed at the same bit positions.
- R4: The lane carry is kept as the result's top bit: 0xFFFF with 0xFFFF gives 0xFFFF, and 0xFFFF with 0x0001 gives 0x8000.
- R5: No carry passes between lanes. A lane that overflows leaves the neighbouring lanes' results unchanged.
- R6: An operation accepted in cycle T, with `opValid` high, writes its result to register `opDst` at the end of cycle T+1. `done` is high in cycle T+1 only, unless another operation was accepted in T+1.
- R7: `rdData` shows register `rdIdx` combinationally. If that register is written in the same cycle, by load or writeback, it shows the value being written.
- R8: If a writeback and a load target the same register in the same cycle, the register takes the writeback value, and `rdData` shows that value during the collision cycle.
- R9: Operand reads use the same bypass. An operation issued in the cycle when an earlier result is written back sees that result as its source.
- R10: Using the same register for both sources returns that register unchanged. The destination may equal a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Issue an average operation this cycle |
| opSrcA | input | 3 | First source register number |
| opSrcB | input | 3 | Second source register number |
| opDst | input | 3 | Destination register number |
| ldEn | input | 1 | Load a full vector this cycle |
| ldIdx | input | 3 | Register number for the load |
| ldData | input | 64 | Vector to load |
| rdIdx | input | 3 | Register number for the read port |
| rdData | output | 64 | Contents of register `rdIdx` (bypassed) |
| done | output | 1 | Writeback of an operation's result this cycle |

## Verification
Directed vectors set every lane to its maximum on both sides, and mix a lane pair that overflows with lanes that do not. These separate a dropped carry from a leaked carry (R4, R5). A mirrored operand pair and identical sources separate correct lane placement from swapped lanes. Back-to-back dependent operations, and a load colliding with a writeback, tell a bypassed file from a plain one and show the write priority. Long random runs of loads, operations and reads, compared against a bench model of the file, catch timing slips in the done pulse and in writeback.

// File: rtl/vavg_pkg.sv
package vavg_pkg;
  localparam int LANE_W = 16;
  localparam int LANES  = 4;
  localparam int REGS   = 8;
  localparam int VEC_W  = LANE_W * LANES;
  localparam int IDX_W  = $clog2(REGS);

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [IDX_W-1:0] idx_t;

  // control to datapath strobes
  typedef struct packed {
    logic capture;
    logic wbEn;
    idx_t wbIdx;
  } vavgStrobes_t;
endpackage

// File: rtl/vavg_lane.sv
module vavg_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] laneA,
  input  logic [W-1:0] laneB,
  output logic [W-1:0] laneAvg
);
  logic [W:0] laneSum;
  logic [W-1:0] loVal;
  logic [W-1:0] hiVal;

  always_comb begin
    laneSum = {1'b0, laneA} + {1'b0, laneB};
    laneAvg = laneSum[W:1];
  end

  always_comb begin
    loVal = (laneA < laneB) ? laneA : laneB;
    hiVal = (laneA < laneB) ? laneB : laneA;
  end

  // R4
  always_comb begin
    avg_bounds_chk: assert (laneAvg >= loVal && laneAvg <= hiVal)
      else $error("lane mean outside operand range");
  end
endmodule

// File: rtl/vavg_ctrl.sv
module vavg_ctrl
  import vavg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         opValid,
  input  idx_t         opDst,
  output vavgStrobes_t strobes,
  output logic         done
);
  logic pendQ;
  idx_t dstQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      dstQ  <= '0;
    end else begin
      pendQ <= opValid;
      if (opValid) dstQ <= opDst;
    end
  end

  always_comb begin
    strobes.capture = opValid;
    strobes.wbEn    = pendQ;
    strobes.wbIdx   = dstQ;
    done            = pendQ;
  end

  // R6
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> done);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !done);
  // R6
  wb_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> strobes.wbIdx == $past(opDst));
endmodule

// File: rtl/vavg_dpath.sv
module vavg_dpath
  import vavg_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  vavgStrobes_t strobes,
  input  idx_t         srcA,
  input  idx_t         srcB,
  input  logic         ldEn,
  input  idx_t         ldIdx,
  input  vec_t         ldData,
  input  idx_t         rdIdx,
  output vec_t         rdData
);
  logic [REGS-1:0][VEC_W-1:0] regs;
  logic [REGS-1:0][VEC_W-1:0] nextRegs;
  vec_t resQ;
  vec_t opA;
  vec_t opB;
  vec_t laneOut;

  // next-state view of the file; writeback has priority over load
  always_comb begin
    for (int r = 0; r < REGS; r++) begin
      if (strobes.wbEn && strobes.wbIdx == idx_t'(r))
        nextRegs[r] = resQ;
      else if (ldEn && ldIdx == idx_t'(r))
        nextRegs[r] = ldData;
      else
        nextRegs[r] = regs[r];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < REGS; r++) regs[r] <= '0;
    end else begin
      for (int r = 0; r < REGS; r++) regs[r] <= nextRegs[r];
    end
  end

  // bypassed reads
  always_comb begin
    opA    = nextRegs[srcA];
    opB    = nextRegs[srcB];
    rdData = nextRegs[rdIdx];
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vavg_lane #(.W(LANE_W)) u_lane (
      .laneA  (opA[k*LANE_W +: LANE_W]),
      .laneB  (opB[k*LANE_W +: LANE_W]),
      .laneAvg(laneOut[k*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN)                resQ <= '0;
    else if (strobes.capture) resQ <= laneOut;
  end

  // R6
  wb_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wbEn |=> regs[$past(strobes.wbIdx)] == $past(resQ));
  // R8
  wb_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.wbEn && ldEn && strobes.wbIdx == ldIdx) |=> regs[$past(ldIdx)] != $past(ldData) || $past(ldData) == $past(resQ));
  // R2
  load_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ldEn && !(strobes.wbEn && strobes.wbIdx == ldIdx)) |=> regs[$past(ldIdx)] == $past(ldData));
  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(resQ));
endmodule

// File: rtl/vavg_unit.sv
module vavg_unit
  import vavg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [IDX_W-1:0] opSrcA,
  input  logic [IDX_W-1:0] opSrcB,
  input  logic [IDX_W-1:0] opDst,
  input  logic             ldEn,
  input  logic [IDX_W-1:0] ldIdx,
  input  logic [VEC_W-1:0] ldData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [VEC_W-1:0] rdData,
  output logic             done
);
  vavgStrobes_t strobes;

  vavg_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opValid(opValid),
    .opDst  (opDst),
    .strobes(strobes),
    .done   (done)
  );

  vavg_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .srcA   (opSrcA),
    .srcB   (opSrcB),
    .ldEn   (ldEn),
    .ldIdx  (ldIdx),
    .ldData (ldData),
    .rdIdx  (rdIdx),
    .rdData (rdData)
  );
endmodule

// File: tb/sim_vavg_unit.sv
module sim_vavg_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [2:0]  opSrcA, opSrcB, opDst;
  logic        ldEn;
  logic [2:0]  ldIdx;
  logic [63:0] ldData;
  logic [2:0]  rdIdx;
  logic [63:0] rdData;
  logic        done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  logic [63:0] mRegs [8];
  logic        mPend;
  logic [2:0]  mDst;
  logic [63:0] mRes;

  vavg_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSrcA(opSrcA), .opSrcB(opSrcB),
    .opDst(opDst), .ldEn(ldEn), .ldIdx(ldIdx), .ldData(ldData), .rdIdx(rdIdx),
    .rdData(rdData), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] refAvg(logic [63:0] a, logic [63:0] b);
    logic [63:0] r;
    for (int k = 0; k < 4; k++) begin
      logic [16:0] s;
      s = {1'b0, a[16*k +: 16]} + {1'b0, b[16*k +: 16]};
      r[16*k +: 16] = s[16:1];
    end
    return r;
  endfunction

  function automatic logic [63:0] viewOf(logic [2:0] idx);
    if (mPend && mDst == idx) return mRes;
    if (ldEn && ldIdx == idx) return ldData;
    return mRegs[idx];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // inputs already set; check at mid-low phase, then advance model across edge
  task automatic step(string req);
    logic [63:0] nxt [8];
    logic [63:0] newRes;
    #(CLK_PERIOD/4);
    check(req, rdData, viewOf(rdIdx));
    check("R6", {63'd0, done}, {63'd0, mPend});
    for (int r = 0; r < 8; r++) nxt[r] = viewOf(3'(r));
    newRes = refAvg(viewOf(opSrcA), viewOf(opSrcB));
    @(posedge clk);
    for (int r = 0; r < 8; r++) mRegs[r] = nxt[r];
    if (opValid) begin mRes = newRes; mDst = opDst; end
    mPend = opValid;
    @(negedge clk);
  endtask

  task automatic idle();
    opValid = 0; ldEn = 0;
  endtask

  task automatic doLoad(logic [2:0] i, logic [63:0] d, string req);
    idle(); ldEn = 1; ldIdx = i; ldData = d; rdIdx = i; step(req);
  endtask

  task automatic doOp(logic [2:0] a, logic [2:0] b, logic [2:0] d, logic [2:0] rd, string req);
    idle(); opValid = 1; opSrcA = a; opSrcB = b; opDst = d; rdIdx = rd; step(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected <= %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rstN = 0; opValid = 0; ldEn = 0; opSrcA = 0; opSrcB = 0; opDst = 0;
    ldIdx = 0; ldData = '0; rdIdx = 0;
    for (int r = 0; r < 8; r++) mRegs[r] = '0;
    mPend = 0; mDst = 0; mRes = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;

    // R1: reset state of every register
    for (int r = 0; r < 8; r++) begin
      idle(); rdIdx = 3'(r);
      #(CLK_PERIOD/4);
      check("R1", rdData, 64'd0);
      check("R1", {63'd0, done}, 64'd0);
      @(negedge clk);
    end

    // R2: loads
    doLoad(3'd0, 64'hFFFF_0001_8000_FFFF, "R2");
    doLoad(3'd1, 64'hFFFF_FFFF_8000_0001, "R2");
    idle(); rdIdx = 3'd0; step("R2");
    idle(); rdIdx = 3'd1; step("R2");

    // R4 R5: carry kept per lane, no leak; read dst during writeback (R7)
    doOp(3'd0, 3'd1, 3'd2, 3'd2, "R3");
    idle(); rdIdx = 3'd2;
    #(CLK_PERIOD/4);
    check("R7", rdData, 64'hFFFF_8000_8000_8000);
    @(negedge clk);
    // step() model path needs model advance: replay cleanly
    mRegs[2] = 64'hFFFF_8000_8000_8000; mPend = 0;
    idle(); rdIdx = 3'd2; step("R5");
    idle(); rdIdx = 3'd2;
    #(CLK_PERIOD/4);
    check("R4", rdData, 64'hFFFF_8000_8000_8000);
    @(negedge clk);

    // R3: lane placement with mirrored operands
    doLoad(3'd3, 64'h0004_0008_000C_0010, "R2");
    doLoad(3'd4, 64'h0010_000C_0008_0004, "R2");
    doOp(3'd3, 3'd4, 3'd5, 3'd5, "R3");
    idle(); rdIdx = 3'd5; step("R3");
    idle(); rdIdx = 3'd5;
    #(CLK_PERIOD/4);
    check("R3", rdData, 64'h000A_000A_000A_000A);
    @(negedge clk);

    // R9: dependent back-to-back operations
    doOp(3'd3, 3'd3, 3'd6, 3'd6, "R10");
    doOp(3'd6, 3'd4, 3'd7, 3'd6, "R9");
    idle(); rdIdx = 3'd7; step("R9");
    idle(); rdIdx = 3'd7;
    #(CLK_PERIOD/4);
    check("R9", rdData, refAvg(64'h0004_0008_000C_0010, 64'h0010_000C_0008_0004));
    check("R10", mRegs[6], 64'h0004_0008_000C_0010);
    @(negedge clk);

    // R8: load collides with writeback
    doOp(3'd0, 3'd0, 3'd3, 3'd3, "R10");
    idle(); ldEn = 1; ldIdx = 3'd3; ldData = 64'h1234_5678_9ABC_DEF0; rdIdx = 3'd3;
    #(CLK_PERIOD/4);
    check("R8", rdData, 64'hFFFF_0001_8000_FFFF);
    @(negedge clk);
    mRegs[3] = 64'hFFFF_0001_8000_FFFF; mPend = 0;
    idle(); rdIdx = 3'd3; step("R8");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      opValid = ($urandom % 2) == 0;
      ldEn    = ($urandom % 3) == 0;
      opSrcA  = 3'($urandom); opSrcB = 3'($urandom); opDst = 3'($urandom);
      ldIdx   = 3'($urandom);
      ldData  = {$urandom, $urandom};
      if (($urandom % 8) == 0) ldData = {4{16'hFFFF}};
      rdIdx   = (($urandom % 2) == 0 && mPend) ? mDst : 3'($urandom);
      step("R3");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule